// File: doc/BRIEF.md
# Auto-Reload Decrementer

This block is a down-counter that steps once for each time-base tick and raises a sticky status flag when the count runs out. Software can load the count directly and can also program a separate reload value. A control register holds two enables: one for the interrupt and one for automatic reload. The interrupt output is the status flag gated by the interrupt enable.

With auto-reload on, the counter restarts from the reload value each time it expires, which gives a periodic interrupt. With auto-reload off, the counter parks at zero after one expiry, which gives a one-shot. Software acknowledges an expiry by writing a one to the status flag's bit position. Address decoding is done outside the block: each register has its own write strobe and data bus.

Top module: `autoreload_decrementer`

## Requirements
- R1: After reset the count, the reload value, both control enables and the status flag are zero, and `irq` is low.
- R2: On a cycle with `tick` high, no count write and a count above 1, the count drops by exactly one. Without `tick` it holds its value. This applies across the full 32-bit range.
- R3: A tick that moves the count from 1 to 0 is an expiry. An expiry sets the status flag, which is status bit 27.
- R4: With auto-reload off (control bit 22 = 0), an expiry leaves the count at 0. Later ticks keep it at 0 and do not set the status flag again.
- R5: With auto-reload on (control bit 22 = 1), an expiry loads the reload register's value into the count instead of 0.
- R6: A count write takes priority over a decrement or a reload in the same cycle. A count write is never an expiry, including a write of 0.
- R7: `irq` is high exactly while the status flag and the interrupt enable (control bit 26) are both 1. A control write keeps only bits 26 and 22.
- R8: A status write with bit 27 set clears the flag. With bit 27 clear, the write leaves the flag unchanged, whatever its other bits are.
- R9: If an expiry and a status clear fall in the same cycle, the flag ends up set.
- R10: A write to the reload register does not change the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time-base tick enable |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 32 | Count write data |
| rld_we | input | 1 | Reload register write strobe |
| rld_wdata | input | 32 | Reload register write data |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control write data (bit 26 interrupt enable, bit 22 auto-reload) |
| sts_we | input | 1 | Status write strobe (write one to clear) |
| sts_wdata | input | 32 | Status write data (bit 27 is the flag) |
| irq | output | 1 | Decrementer interrupt |
| cnt_value | output | 32 | Current count |

## Verification
The bench builds the block with its default parameters: a 32-bit count, control bit positions 26 and 22, and status bit 27. It loads small counts so that one-shot expiry, parking at zero and periodic reload all happen within a few ticks. It also writes an all-ones count to exercise the decrement at the top of the 32-bit range. The 32-bit control and status buses let the bench write every other bit position alongside the enables and the flag, to show that those bits have no effect.

// File: rtl/decr_pkg.sv
package decr_pkg;

  typedef struct packed {
    logic irq_en;
    logic auto_rld;
  } decr_ctl_t;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_LOAD,
    OP_DEC,
    OP_RELOAD,
    OP_PARK
  } decr_op_e;

  // Picks what the counter does this cycle; a software load wins over everything.
  function automatic decr_op_e pick_op(input logic wr, input logic tick,
                                       input logic at_zero, input logic at_one,
                                       input logic auto_rld);
    if (wr)                       return OP_LOAD;
    else if (!tick)               return OP_HOLD;
    else if (at_zero)             return OP_PARK;
    else if (at_one && auto_rld)  return OP_RELOAD;
    else                          return OP_DEC;
  endfunction

  // New flag value: a set beats a clear in the same cycle.
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/decr_counter.sv
module decr_counter
  import decr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] rld_val,
  input  logic         auto_rld,
  output logic [W-1:0] count,
  output logic         expire
);

  localparam logic [W-1:0] ONE = W'(1);

  logic     at_zero, at_one;
  decr_op_e op;
  logic [W-1:0] cnt_d;

  assign at_zero = (count == '0);
  assign at_one  = (count == ONE);

  always_comb begin
    op = pick_op(wr, tick, at_zero, at_one, auto_rld);
    unique case (op)
      OP_LOAD:   cnt_d = wdata;
      OP_DEC:    cnt_d = count - ONE;
      OP_RELOAD: cnt_d = rld_val;
      OP_PARK:   cnt_d = '0;
      default:   cnt_d = count;
    endcase
  end

  // Expiry: a tick (not overridden by a write) that consumes the last unit.
  assign expire = tick & ~wr & at_one;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_d;
  end

endmodule

// File: rtl/decr_reg.sv
module decr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end

endmodule

// File: rtl/decr_ctl_reg.sv
module decr_ctl_reg
  import decr_pkg::*;
#(
  parameter int CW      = 32,
  parameter int IE_POS  = 26,
  parameter int ARE_POS = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  output decr_ctl_t     ctl
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (we) begin
      ctl.irq_en   <= wdata[IE_POS];
      ctl.auto_rld <= wdata[ARE_POS];
    end
  end

endmodule

// File: rtl/decr_flag.sv
module decr_flag
  import decr_pkg::*;
#(
  parameter int SW     = 32,
  parameter int ST_POS = 27
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic          we,
  input  logic [SW-1:0] wdata,
  output logic          flag
);

  logic clr;
  assign clr = we & wdata[ST_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_next(flag, set, clr);
  end

endmodule

// File: rtl/autoreload_decrementer.sv
module autoreload_decrementer
  import decr_pkg::*;
#(
  parameter int W       = 32,
  parameter int CW      = 32,
  parameter int IE_POS  = 26,
  parameter int ARE_POS = 22,
  parameter int ST_POS  = 27
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cnt_we,
  input  logic [W-1:0]  cnt_wdata,
  input  logic          rld_we,
  input  logic [W-1:0]  rld_wdata,
  input  logic          ctl_we,
  input  logic [CW-1:0] ctl_wdata,
  input  logic          sts_we,
  input  logic [CW-1:0] sts_wdata,
  output logic          irq,
  output logic [W-1:0]  cnt_value
);

  // Named internal events for the checker.
  logic [W-1:0] cnt_q;
  logic [W-1:0] rld_q;
  decr_ctl_t    ctl_q;
  logic         sts_q;
  logic         expire_evt;

  decr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr(cnt_we), .wdata(cnt_wdata),
    .rld_val(rld_q), .auto_rld(ctl_q.auto_rld), .count(cnt_q),
    .expire(expire_evt)
  );

  decr_reg #(.W(W)) u_rld (
    .clk(clk), .rst_n(rst_n), .we(rld_we), .wdata(rld_wdata), .q(rld_q)
  );

  decr_ctl_reg #(.CW(CW), .IE_POS(IE_POS), .ARE_POS(ARE_POS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata), .ctl(ctl_q)
  );

  decr_flag #(.SW(CW), .ST_POS(ST_POS)) u_sts (
    .clk(clk), .rst_n(rst_n), .set(expire_evt), .we(sts_we),
    .wdata(sts_wdata), .flag(sts_q)
  );

  assign irq       = sts_q & ctl_q.irq_en;
  assign cnt_value = cnt_q;

endmodule

// File: rtl/decr_checker.sv
module decr_checker #(
  parameter int W      = 32,
  parameter int CW     = 32,
  parameter int ST_POS = 27
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          cnt_we,
  input logic [W-1:0]  cnt_wdata,
  input logic          sts_we,
  input logic [CW-1:0] sts_wdata,
  input logic [W-1:0]  cnt_q,
  input logic [W-1:0]  rld_q,
  input logic          auto_rld,
  input logic          sts_q,
  input logic          expire_evt,
  input logic          irq
);

  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && cnt_q > W'(1)) |=> cnt_q == $past(cnt_q) - W'(1));

  a_r3_expiry_sets: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> sts_q);

  a_r4_park_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !cnt_we) |=> cnt_q == '0);

  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && auto_rld) |=> cnt_q == $past(rld_q));

  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_q == $past(cnt_wdata));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_we && sts_wdata[ST_POS] && !expire_evt) |=> !sts_q);

  a_r7_no_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_q |-> !irq);

endmodule

bind autoreload_decrementer decr_checker #(.W(W), .CW(CW), .ST_POS(ST_POS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we),
  .cnt_wdata(cnt_wdata), .sts_we(sts_we), .sts_wdata(sts_wdata),
  .cnt_q(cnt_q), .rld_q(rld_q), .auto_rld(ctl_q.auto_rld), .sts_q(sts_q),
  .expire_evt(expire_evt), .irq(irq)
);

// File: tb/test_autoreload_decrementer.sv
module test_autoreload_decrementer;

  localparam logic [31:0] IE  = 32'h1 << 26;
  localparam logic [31:0] ARE = 32'h1 << 22;
  localparam logic [31:0] ST  = 32'h1 << 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, cnt_we = 0, rld_we = 0, ctl_we = 0, sts_we = 0;
  logic [31:0] cnt_wdata = '0, rld_wdata = '0, ctl_wdata = '0, sts_wdata = '0;
  logic irq;
  logic [31:0] cnt_value;

  always #5 clk = ~clk;

  autoreload_decrementer i_autoreload_decrementer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .rld_we(rld_we), .rld_wdata(rld_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .sts_we(sts_we),
    .sts_wdata(sts_wdata), .irq(irq), .cnt_value(cnt_value)
  );

  typedef struct {
    logic [31:0] cnt;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  // Bench model state.
  logic [31:0] m_cnt = '0, m_rld = '0;
  logic m_ie = 0, m_are = 0, m_st = 0;

  // Pending stimulus for the next cycle.
  logic b_tick, b_cw, b_rw, b_kw, b_sw;
  logic [31:0] b_cwd, b_rwd, b_kwd, b_swd;

  task automatic clr_b();
    b_tick = 0; b_cw = 0; b_rw = 0; b_kw = 0; b_sw = 0;
    b_cwd = '0; b_rwd = '0; b_kwd = '0; b_swd = '0;
  endtask

  task automatic cyc(input string tag);
    logic ex;
    @(negedge clk);
    tick = b_tick; cnt_we = b_cw; cnt_wdata = b_cwd; rld_we = b_rw;
    rld_wdata = b_rwd; ctl_we = b_kw; ctl_wdata = b_kwd; sts_we = b_sw;
    sts_wdata = b_swd;
    ex = b_tick && !b_cw && (m_cnt == 32'd1);
    if (b_cw)                m_cnt = b_cwd;
    else if (b_tick) begin
      if (m_cnt == 0)        m_cnt = 0;
      else if (m_cnt == 1)   m_cnt = m_are ? m_rld : 32'd0;
      else                   m_cnt = m_cnt - 1;
    end
    m_st = ex || (m_st && !(b_sw && b_swd[27]));
    if (b_rw) m_rld = b_rwd;
    if (b_kw) begin m_ie = b_kwd[26]; m_are = b_kwd[22]; end
    q.push_back('{m_cnt, m_st && m_ie, tag});
    clr_b();
  endtask

  // Monitor: compare after each active edge once outputs have settled.
  initial begin
    forever begin
      exp_t it;
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (cnt_value !== it.cnt || irq !== it.irq) begin
          errors++;
          $display("FAIL %s: cnt=%h irq=%b expected cnt=%h irq=%b",
                   it.tag, cnt_value, irq, it.cnt, it.irq);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clr_b();
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (cnt_value !== 32'd0 || irq !== 1'b0) begin
      errors++;
      $display("FAIL R1: cnt=%h irq=%b expected cnt=0 irq=0", cnt_value, irq);
    end
    @(negedge clk) rst_n = 1'b1;

    b_kw = 1; b_kwd = IE;                       cyc("R7 enable only");
    b_cw = 1; b_cwd = 32'd5; b_tick = 1;        cyc("R6 write beats tick");
    b_tick = 1;                                 cyc("R2 dec");
    b_tick = 1;                                 cyc("R2 dec");
                                                cyc("R2 hold without tick");
    b_tick = 1;                                 cyc("R2 dec");
    b_tick = 1;                                 cyc("R2 dec to one");
    b_tick = 1;                                 cyc("R3 expiry sets flag");
    b_tick = 1;                                 cyc("R4 park at zero");
    b_sw = 1; b_swd = ~ST;                      cyc("R8 bit27 zero keeps flag");
    b_sw = 1; b_swd = ST;                       cyc("R8 clear flag");
    b_tick = 1;                                 cyc("R4 no new expiry at zero");
    b_cw = 1; b_cwd = 32'd0;                    cyc("R6 write zero no expiry");
    b_rw = 1; b_rwd = 32'd3;                    cyc("R10 reload write keeps count");
    b_kw = 1; b_kwd = IE | ARE;                 cyc("R7 enables");
    b_cw = 1; b_cwd = 32'd2;                    cyc("R6 load");
    b_tick = 1;                                 cyc("R2 dec");
    b_tick = 1;                                 cyc("R5 reload at expiry");
    b_tick = 1; b_sw = 1; b_swd = ST;           cyc("R8 clear while counting");
    b_tick = 1;                                 cyc("R2 dec");
    b_tick = 1; b_sw = 1; b_swd = ST;           cyc("R9 set beats clear");
    b_sw = 1; b_swd = ST;                       cyc("R8 clear");
    b_cw = 1; b_cwd = 32'd1;                    cyc("R6 load one");
    b_tick = 1; b_cw = 1; b_cwd = 32'd9;        cyc("R6 write beats reload");
    b_cw = 1; b_cwd = 32'd1;                    cyc("R6 load one");
    b_tick = 1;                                 cyc("R5 reload again");
    b_kw = 1; b_kwd = ~IE;                      cyc("R7 flag set enable off");
    b_kw = 1; b_kwd = IE;                       cyc("R7 enable on shows flag");
    b_kw = 1; b_kwd = ~(IE | ARE);              cyc("R7 other control bits ignored");
    b_cw = 1; b_cwd = 32'hFFFF_FFFF;            cyc("R6 load max");
    b_tick = 1;                                 cyc("R2 dec at top of range");
    b_cw = 1; b_cwd = 32'd1;                    cyc("R6 load one");
    b_tick = 1;                                 cyc("R4 expiry without reload");
    b_tick = 1;                                 cyc("R4 stays zero");
    cyc("idle");
    cyc("idle");
    repeat (3) @(posedge clk);
    #3;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule